// File: doc/BRIEF.md
# Cache Block Maintenance Sequencer

This block executes cache-block maintenance commands, one at a time, for a write-back data cache whose lines are each held in one of three coherence states: Invalid, Exclusive (clean) or Modified (dirty). A caller presents a command code, the block address and the line's current state. The sequencer works out the line's next state and whether a bus transaction is needed. It then runs that transaction over a request/acknowledge handshake, writes the new state back through a one-cycle strobe, and signals completion.

A barrier command issues no transaction. It waits until the memory queues report that they are empty. The two touch commands prefetch a missing block with a read or a read-for-ownership. The fetched block goes into a single-entry touch buffer and not into the cache, so the line state stays unchanged. Only one command is in flight at a time, and the caller sees a busy flag for the whole of it.

Top module: `cmo_sequencer`

## Requirements
- R1: Barrier (op 3'd0) issues no bus request and no state write. It pulses done exactly one cycle after the first clock edge at which queues_empty is sampled high, and never earlier.
- R2: Instruction invalidate (op 3'd1) and data invalidate (op 3'd2) write state I (2'b00) from any state with no bus request.
- R3: Flush (op 3'd3) writes I. From M (2'b10) it first issues write-with-kill (type 3'd4). From I or E (2'b01) it issues nothing.
- R4: Clean (op 3'd4) from M issues write (type 3'd3) and writes E. From I or E it issues nothing and writes back the unchanged state.
- R5: Zero (op 3'd5) writes M. From I it issues write-with-kill (3'd4). From E or M it issues kill-block (3'd5).
- R6: Touch-for-load (op 3'd6) from I issues read (type 3'd1). From E or M it issues nothing. It always writes back the unchanged state.
- R7: Touch-for-store (op 3'd7) from I issues read-for-ownership (type 3'd2). From E or M it issues nothing. It always writes back the unchanged state.
- R8: Line state 2'b11 is handled exactly as I, including the value that is written back.
- R9: bus_req is held, with bus_type and bus_addr stable, until bus_ack is sampled high. state_we and done pulse for one cycle, either in the cycle after acknowledge or in the cycle after acceptance when no transaction is needed.
- R10: A command is accepted only while busy is low. busy stays high from the cycle after acceptance through the done cycle. cmd_valid while busy is ignored.
- R11: The touch buffer becomes valid with the command's address when a touch read is acknowledged. A later acknowledged touch replaces it. Other commands leave it unchanged.
- R12: While the chip is in reset and after reset, busy, bus_req, state_we, done and touch_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | AW | Block address |
| line_state | input | 2 | Current line state (00 I, 01 E, 10 M, 11 treated as I) |
| queues_empty | input | 1 | Memory queues have no outstanding bus activity |
| bus_ack | input | 1 | Bus transaction acknowledge |
| busy | output | 1 | Command in progress |
| bus_req | output | 1 | Bus transaction request |
| bus_type | output | 3 | Transaction type (0 none, 1 read, 2 read-for-ownership, 3 write, 4 write-with-kill, 5 kill-block) |
| bus_addr | output | AW | Transaction address |
| state_we | output | 1 | Line-state write strobe |
| state_wdata | output | 2 | New line state |
| done | output | 1 | Command complete |
| touch_valid | output | 1 | Touch buffer holds an entry |
| touch_addr | output | AW | Address held in the touch buffer |

## Verification
Every result has a fixed latency measured from the accepting edge. A command that needs a transaction shows bus_req one cycle after acceptance. state_we and done follow one cycle after the acknowledging edge. A command without a transaction shows state_we and done one cycle after acceptance. A barrier shows done one cycle after the edge at which queues_empty is first seen high. The touch buffer is updated on the same edge as the done cycle. The bench drives inputs and samples outputs on falling edges, and it steps through exactly these edge counts. It sweeps every command against every line state with several acknowledge and drain delays, and it pokes cmd_valid while busy.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_EXC = 2'b01,
    LS_MOD = 2'b10,
    LS_RSV = 2'b11
  } line_st_e;

  typedef enum logic [2:0] {
    OP_BARRIER = 3'd0,
    OP_IINV    = 3'd1,
    OP_DINV    = 3'd2,
    OP_FLUSH   = 3'd3,
    OP_CLEAN   = 3'd4,
    OP_ZERO    = 3'd5,
    OP_TLOAD   = 3'd6,
    OP_TSTORE  = 3'd7
  } cmd_op_e;

  typedef enum logic [2:0] {
    BT_NONE  = 3'd0,
    BT_READ  = 3'd1,
    BT_RFO   = 3'd2,
    BT_WRITE = 3'd3,
    BT_WKILL = 3'd4,
    BT_KILL  = 3'd5
  } bus_op_e;

  typedef struct packed {
    line_st_e nxt;
    bus_op_e  bop;
  } cmo_action_t;
endpackage

// File: rtl/cmo_rst_sync.sv
module cmo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmo_decode.sv
module cmo_decode
  import cmo_pkg::*;
(
  input  logic [2:0]  op,
  input  logic [1:0]  cur,
  output cmo_action_t act
);
  line_st_e st;
  logic     miss;
  logic     dirty;

  always_comb begin
    st    = (cur == LS_RSV) ? LS_INV : line_st_e'(cur);
    miss  = (st == LS_INV);
    dirty = (st == LS_MOD);
    act.nxt = st;
    act.bop = BT_NONE;
    case (cmd_op_e'(op))
      OP_IINV, OP_DINV: act.nxt = LS_INV;
      OP_FLUSH: begin
        act.nxt = LS_INV;
        if (dirty) act.bop = BT_WKILL;
      end
      OP_CLEAN: begin
        if (dirty) begin
          act.bop = BT_WRITE;
          act.nxt = LS_EXC;
        end
      end
      OP_ZERO: begin
        act.nxt = LS_MOD;
        act.bop = miss ? BT_WKILL : BT_KILL;
      end
      OP_TLOAD:  if (miss) act.bop = BT_READ;
      OP_TSTORE: if (miss) act.bop = BT_RFO;
      default: ;
    endcase
  end
endmodule

// File: rtl/cmo_ctrl.sv
module cmo_ctrl
  import cmo_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  cmo_action_t   act,
  input  logic          queues_empty,
  input  logic          bus_ack,
  output logic          busy,
  output logic          bus_req,
  output logic [2:0]    bus_type,
  output logic [AW-1:0] bus_addr,
  output logic          state_we,
  output logic [1:0]    state_wdata,
  output logic          done,
  output logic          touch_load
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_DRAIN, S_WB, S_FIN} seq_st_e;

  seq_st_e     st_q, st_d;
  cmo_action_t act_q;
  cmd_op_e     op_q;
  logic [AW-1:0] addr_q;
  logic        accept;

  assign accept = (st_q == S_IDLE) && cmd_valid;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (cmd_valid) begin
        if (cmd_op_e'(cmd_op) == OP_BARRIER) st_d = S_DRAIN;
        else if (act.bop != BT_NONE)         st_d = S_REQ;
        else                                 st_d = S_WB;
      end
      S_REQ:   if (bus_ack) st_d = S_WB;
      S_DRAIN: if (queues_empty) st_d = S_FIN;
      S_WB, S_FIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '{nxt: LS_INV, bop: BT_NONE};
      op_q   <= OP_BARRIER;
      addr_q <= '0;
    end else if (accept) begin
      act_q  <= act;
      op_q   <= cmd_op_e'(cmd_op);
      addr_q <= cmd_addr;
    end
  end

  assign busy        = (st_q != S_IDLE);
  assign bus_req     = (st_q == S_REQ);
  assign bus_type    = bus_req ? act_q.bop : BT_NONE;
  assign bus_addr    = addr_q;
  assign state_we    = (st_q == S_WB);
  assign state_wdata = state_we ? act_q.nxt : LS_INV;
  assign done        = (st_q == S_WB) || (st_q == S_FIN);
  assign touch_load  = bus_req && bus_ack &&
                       ((op_q == OP_TLOAD) || (op_q == OP_TSTORE));
endmodule

// File: rtl/cmo_touch_buf.sv
module cmo_touch_buf #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  output logic          valid,
  output logic [AW-1:0] addr
);
  logic          valid_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    valid_d = valid | load;
    addr_d  = load ? load_addr : addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
    end else begin
      valid <= valid_d;
      addr  <= addr_d;
    end
  end
endmodule

// File: rtl/cmo_sequencer.sv
module cmo_sequencer
  import cmo_pkg::*;
#(
  parameter int AW        = 32,
  parameter int RST_STAGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [1:0]    line_state,
  input  logic          queues_empty,
  input  logic          bus_ack,
  output logic          busy,
  output logic          bus_req,
  output logic [2:0]    bus_type,
  output logic [AW-1:0] bus_addr,
  output logic          state_we,
  output logic [1:0]    state_wdata,
  output logic          done,
  output logic          touch_valid,
  output logic [AW-1:0] touch_addr
);
  logic        rst_sync_n;
  cmo_action_t act;
  logic        touch_load;

  cmo_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cmo_decode u_dec (.op(cmd_op), .cur(line_state), .act(act));

  cmo_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .act(act), .queues_empty(queues_empty),
    .bus_ack(bus_ack), .busy(busy), .bus_req(bus_req), .bus_type(bus_type),
    .bus_addr(bus_addr), .state_we(state_we), .state_wdata(state_wdata),
    .done(done), .touch_load(touch_load)
  );

  cmo_touch_buf #(.AW(AW)) u_touch (
    .clk(clk), .rst_n(rst_sync_n), .load(touch_load), .load_addr(bus_addr),
    .valid(touch_valid), .addr(touch_addr)
  );
endmodule

// File: rtl/cmo_checker.sv
module cmo_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          bus_req,
  input logic          bus_ack,
  input logic [2:0]    bus_type,
  input logic [AW-1:0] bus_addr,
  input logic          state_we,
  input logic [1:0]    state_wdata,
  input logic          done,
  input logic          touch_valid,
  input logic [AW-1:0] touch_addr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_type) && $stable(bus_addr)); // R9
  AST_WE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> state_we && done && !bus_req); // R9
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |=> !state_we); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req && !state_we && !done); // R10
  AST_NO_RSV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |-> state_wdata != 2'b11); // R8
  AST_REQ_TYPED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_type != 3'd0 && bus_type <= 3'd5); // R9
  AST_TOUCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && (bus_type == 3'd1 || bus_type == 3'd2)
    |=> touch_valid && touch_addr == $past(bus_addr)); // R11
  AST_TOUCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    touch_valid |=> touch_valid); // R11
endmodule

bind cmo_sequencer cmo_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy), .bus_req(bus_req),
  .bus_ack(bus_ack), .bus_type(bus_type), .bus_addr(bus_addr),
  .state_we(state_we), .state_wdata(state_wdata), .done(done),
  .touch_valid(touch_valid), .touch_addr(touch_addr)
);

// File: tb/test_cmo_sequencer.sv
module test_cmo_sequencer;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [1:0]    line_state;
  logic          queues_empty;
  logic          bus_ack;
  logic          busy, bus_req, state_we, done, touch_valid;
  logic [2:0]    bus_type;
  logic [AW-1:0] bus_addr, touch_addr;
  logic [1:0]    state_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit          exp_tv = 1'b0;
  logic [AW-1:0] exp_ta = '0;

  always #2.5 clk = ~clk;

  cmo_sequencer #(.AW(AW)) i_cmo_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .line_state(line_state), .queues_empty(queues_empty),
    .bus_ack(bus_ack), .busy(busy), .bus_req(bus_req), .bus_type(bus_type),
    .bus_addr(bus_addr), .state_we(state_we), .state_wdata(state_wdata),
    .done(done), .touch_valid(touch_valid), .touch_addr(touch_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0: return "R1";
      1, 2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Expected outcome from the requirement table: {type, next state}
  task automatic model(input int op, input int st, output int t, output int ns);
    int s;
    s = (st == 3) ? 0 : st;   // R8
    t = 0; ns = s;
    case (op)
      1, 2: ns = 0;
      3: begin ns = 0; if (s == 2) t = 4; end
      4: if (s == 2) begin t = 3; ns = 1; end
      5: begin ns = 2; t = (s == 0) ? 4 : 5; end
      6: if (s == 0) t = 1;
      7: if (s == 0) t = 2;
      default: ;
    endcase
  endtask

  task automatic run_cmd(input int op, input int st, input logic [AW-1:0] addr,
                         input int dly, input bit poke);
    int t, ns;
    string tag, rtag;
    model(op, st, t, ns);
    tag  = op_tag(op);
    rtag = (st == 3 && op != 0) ? "R8" : tag;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = addr; line_state = 2'(st);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; line_state = 2'(3 - st);
    chk("R10 busy after accept", 64'(busy), 64'd1);
    if (op == 0) begin
      for (int i = 0; i <= dly; i++) begin
        chk("R1 waiting", {61'd0, done, bus_req, state_we}, 64'd0);
        cmd_valid = poke;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      queues_empty = 1'b1;
      @(negedge clk);
      queues_empty = 1'b0;
      chk("R1 done", {61'd0, done, bus_req, state_we}, 64'b100);
    end else if (t != 0) begin
      for (int i = 0; i < dly; i++) begin
        chk({tag, " R9 req held"}, {bus_req, bus_type, done, bus_addr},
            {1'b1, 3'(t), 1'b0, addr});
        cmd_valid = poke; cmd_op = 3'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      chk({rtag, " req"}, {bus_req, bus_type, done, bus_addr}, {1'b1, 3'(t), 1'b0, addr});
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
      chk({rtag, " R9 write after ack"}, {bus_req, state_we, done, state_wdata},
          {1'b0, 1'b1, 1'b1, 2'(ns)});
    end else begin
      chk({rtag, " no bus write"}, {bus_req, bus_type, state_we, done, state_wdata},
          {1'b0, 3'd0, 1'b1, 1'b1, 2'(ns)});
    end
    if ((op == 6 || op == 7) && t != 0) begin
      exp_tv = 1'b1; exp_ta = addr;
    end
    @(negedge clk);
    chk("R10 idle after done", {busy, bus_req, done, state_we}, 64'd0);
    chk("R11 touch buffer", {touch_valid, touch_addr}, {exp_tv, exp_ta});
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; line_state = '0;
    queues_empty = 1'b0; bus_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 in reset", {busy, bus_req, state_we, done, touch_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 after reset", {busy, bus_req, state_we, done, touch_valid}, 64'd0);
    for (int pass = 0; pass < 2; pass++)
      for (int op = 0; op < 8; op++)
        for (int st = 0; st < 4; st++)
          run_cmd(op, st, 32'h4000_0000 + 32'(pass * 4096 + op * 256 + st * 16),
                  (op + st + pass) % 4, pass[0]);
    // R11 replacement: load touch then store touch at a new address
    run_cmd(6, 0, 32'h0000_A000, 1, 1'b0);
    run_cmd(7, 3, 32'h0000_B000, 0, 1'b0);
    run_cmd(4, 2, 32'h0000_C000, 2, 1'b1);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule